// File: doc/BRIEF.md
# Ring Oscillator Performance Monitor

This block measures how fast the silicon is running at its present process, voltage and temperature. It has several channels. Each channel picks one of its ring oscillators and counts that ring's rising edges over a window. The window length is set as a number of reference-clock cycles. With a 24 MHz reference, a window of T microseconds is programmed as T×24. A fast ring produces a large count and a slow ring a small one, so software can compare the count against characterised limits.

Software reaches the block through a plain register port with one write port and one combinational read port.

- **Control word.** A single 16-bit word holds, for every channel, a start bit, an enable bit and a 2-bit ring selector. A write changes only the bits whose mask bit in the upper half of the write data is set, so software never has to read the word first.
- **Wide channel.** One channel has more rings than a 2-bit selector can reach. It takes a third, most-significant select bit from a separate masked register.
- **Per-channel registers.** Each channel has its own window-length register, a done flag in a shared status word and a saturating result register.

To take a measurement, software does the following in order:

1. Set the channel's enable bit.
2. Choose the ring.
3. Load the window length.
4. Set the start bit.
5. Poll the done flag.
6. Read the result.
7. Clear the start bit, then clear the enable bit.

The rings are behavioural models: each one divides a test clock by a fixed amount. Their outputs pass through a two-flop synchroniser and a rising-edge detector before they reach the counter.

Top module: `ring_perf_mon`

## Requirements
- R1: A write to the control word at offset 0x00 updates bit i (0..15) only when data bit 16+i is set. Channel n uses bit 4n as start, bit 4n+1 as enable, and bits 4n+3:4n+2 as ring selector.
- R2: The extension register at offset 4×(channels+1) (0x14 by default) holds one bit at bit 0, which changes only when data bit 16 is set. The wide channel (channel 1) measures ring {extension bit, selector}.
- R3: The window register at offset 4(n+1) holds a count of reference cycles W. Done rises exactly W+2 reference edges after the edge that stores a rising start bit, W=0 included.
- R4: Ring r of a channel toggles every 3+r test-clock cycles. The result equals the number of that ring's rising edges seen during the W counting cycles, to within one.
- R5: A rising start bit while enable is clear starts nothing. Done stays low and the result register keeps its value.
- R6: Clearing the start bit drops done by the second reference edge. Setting start again begins a new measurement with the count back at zero.
- R7: Clearing enable during a measurement aborts it, and done never rises for that run.
- R8: The result register saturates at all ones instead of wrapping.
- R9: The last channel (channel 3) has a single ring and no selector. Its selector bits 15:14 read as zero and cannot be written.
- R10: The wide channel has 6 rings. Selector values 6 and 7 select no ring and give a result of 0.
- R11: After reset, every register reads 0 and no done flag is set.
- R12: The status word at offset 0x20 shows the done flag of channel n at bit n. Channels run independently, and results sit at 0x24+4n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_clk | input | 1 | Test clock that the behavioural rings divide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | 32 | Write data; upper half carries masks for the masked registers |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | 32 | Read data, combinational |

## Verification
On every cycle, the bound checker enforces the channel state rules for each channel:
- A cleared enable forces the channel idle on the next edge.
- A cleared start forces done low on the next edge.
- Done only ever follows a running phase, and a channel is never running and done at once.
- Every accepted start leads to a running phase.

Some behaviours can only be shown by the bench's scenarios, because they need full measurements to complete:
- the exact W+2 latency;
- the count for each ring, compared against the divide ratio;
- saturation;
- masked-write behaviour, including the hidden selector bits of the single-ring channel;
- the silent selector values on the wide channel;
- concurrent channels.

The bench sweeps every selector value of every channel.

// File: rtl/rpm_pkg.sv
package rpm_pkg;

  localparam int CTRL_BITS   = 16;
  localparam int BITS_PER_CH = 4;
  localparam int RIDX_W      = 3;

  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_RUN  = 2'd1,
    CH_DONE = 2'd2
  } ch_state_e;

  function automatic int start_bit(int ch);
    return ch * BITS_PER_CH;
  endfunction

  function automatic int enable_bit(int ch);
    return ch * BITS_PER_CH + 1;
  endfunction

  function automatic int sel_bit(int ch);
    return ch * BITS_PER_CH + 2;
  endfunction

  // Number of rings that a given channel owns.
  function automatic int ring_count(int ch, int wide_ch, int single_ch,
                                    int wide_rings, int std_rings);
    if (ch == single_ch) return 1;
    if (ch == wide_ch)   return wide_rings;
    return std_rings;
  endfunction

  // Half-period of ring r, in test-clock cycles.
  function automatic int ring_half_period(int base_div, int r);
    return base_div + r;
  endfunction

  // Masked update: bit i takes the new value only where mask bit 16+i is set.
  function automatic logic [CTRL_BITS-1:0] hiword_merge(logic [CTRL_BITS-1:0] cur,
                                                        logic [31:0] wd);
    return (cur & ~wd[31:16]) | (wd[15:0] & wd[31:16]);
  endfunction

  // Control bits that physically exist for a given channel configuration.
  function automatic logic [CTRL_BITS-1:0] ctrl_keep_mask(int num_ch, int single_ch);
    logic [CTRL_BITS-1:0] m;
    m = '0;
    for (int c = 0; c < num_ch; c++) begin
      m[start_bit(c)]  = 1'b1;
      m[enable_bit(c)] = 1'b1;
      if (c != single_ch) begin
        m[sel_bit(c)]     = 1'b1;
        m[sel_bit(c) + 1] = 1'b1;
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/rpm_ring_osc.sv
// Behavioural ring oscillator: a divided copy of the test clock.
module rpm_ring_osc #(
  parameter int DIV = 3
) (
  input  logic osc_clk,
  input  logic rst_n,
  output logic ring_o
);

  localparam int CW = $clog2(DIV + 1);

  logic [CW-1:0] tick_q;

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      ring_o <= 1'b0;
    end else if (tick_q == CW'(DIV - 1)) begin
      tick_q <= '0;
      ring_o <= ~ring_o;
    end else begin
      tick_q <= tick_q + 1'b1;
    end
  end

endmodule

// File: rtl/rpm_ring_bank.sv
// The rings of one channel and the selector that picks one of them.
module rpm_ring_bank import rpm_pkg::*; #(
  parameter int NUM_RINGS = 4,
  parameter int BASE_DIV  = 3
) (
  input  logic              osc_clk,
  input  logic              rst_n,
  input  logic [RIDX_W-1:0] ring_sel,
  output logic              ring_o
);

  logic [NUM_RINGS-1:0] ring_w;

  for (genvar r = 0; r < NUM_RINGS; r++) begin : g_ring
    rpm_ring_osc #(
      .DIV(ring_half_period(BASE_DIV, r))
    ) u_osc (
      .osc_clk(osc_clk),
      .rst_n  (rst_n),
      .ring_o (ring_w[r])
    );
  end

  // Selector values beyond the last ring give a silent output.
  always_comb begin
    ring_o = 1'b0;
    for (int r = 0; r < NUM_RINGS; r++) begin
      if (ring_sel == RIDX_W'(r)) ring_o = ring_w[r];
    end
  end

endmodule

// File: rtl/rpm_chan.sv
// One measurement channel: synchroniser, edge detector, window timer and counter.
module rpm_chan import rpm_pkg::*; #(
  parameter int RES_W = 32,
  parameter int WIN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ring_i,
  input  logic             enable_i,
  input  logic             start_i,
  input  logic [WIN_W-1:0] win_len_i,
  output logic             go_o,
  output logic             run_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o
);

  logic            sync1_q, sync2_q, sync3_q;
  logic            start_q;
  logic            ring_rise;
  ch_state_e       state_q;
  logic [WIN_W-1:0] win_q;
  logic [RES_W-1:0] edges_q;

  function automatic logic [RES_W-1:0] sat_inc(logic [RES_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      sync3_q <= 1'b0;
      start_q <= 1'b0;
    end else begin
      sync1_q <= ring_i;
      sync2_q <= sync1_q;
      sync3_q <= sync2_q;
      start_q <= start_i;
    end
  end

  assign ring_rise = sync2_q & ~sync3_q;

  // A measurement is accepted only on a rising start while enabled.
  assign go_o = enable_i & start_i & ~start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= CH_IDLE;
      win_q    <= '0;
      edges_q  <= '0;
      result_o <= '0;
    end else begin
      case (state_q)
        CH_IDLE: begin
          if (go_o) begin
            state_q  <= CH_RUN;
            win_q    <= win_len_i;
            edges_q  <= '0;
            result_o <= '0;
          end
        end
        CH_RUN: begin
          if (!enable_i || !start_i) begin
            state_q <= CH_IDLE;
          end else if (win_q == '0) begin
            state_q  <= CH_DONE;
            result_o <= edges_q;
          end else begin
            win_q <= win_q - 1'b1;
            if (ring_rise) edges_q <= sat_inc(edges_q);
          end
        end
        CH_DONE: begin
          if (!enable_i || !start_i) state_q <= CH_IDLE;
        end
        default: state_q <= CH_IDLE;
      endcase
    end
  end

  assign run_o  = (state_q == CH_RUN);
  assign done_o = (state_q == CH_DONE);

endmodule

// File: rtl/rpm_regs.sv
// Writable registers: masked control word, masked extension bit and window lengths.
module rpm_regs import rpm_pkg::*; #(
  parameter int NUM_CH    = 4,
  parameter int WIN_W     = 32,
  parameter int ADDR_W    = 8,
  parameter int SINGLE_CH = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [31:0]                  wr_data,
  output logic [CTRL_BITS-1:0]         ctrl_q,
  output logic                         ext_q,
  output logic [NUM_CH-1:0][WIN_W-1:0] win_q
);

  localparam logic [ADDR_W-1:0]    CTRL_ADDR = '0;
  localparam logic [ADDR_W-1:0]    EXT_ADDR  = ADDR_W'(4 * (NUM_CH + 1));
  localparam logic [CTRL_BITS-1:0] KEEP      = ctrl_keep_mask(NUM_CH, SINGLE_CH);

  logic ctrl_hit, ext_hit;

  assign ctrl_hit = wr_en && (wr_addr == CTRL_ADDR);
  assign ext_hit  = wr_en && (wr_addr == EXT_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ext_q  <= 1'b0;
    end else begin
      if (ctrl_hit)               ctrl_q <= hiword_merge(ctrl_q, wr_data) & KEEP;
      if (ext_hit && wr_data[16]) ext_q  <= wr_data[0];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_win
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win_q[c] <= '0;
      end else if (wr_en && (wr_addr == ADDR_W'(4 * (c + 1)))) begin
        win_q[c] <= wr_data[WIN_W-1:0];
      end
    end
  end

endmodule

// File: rtl/ring_perf_mon.sv
module ring_perf_mon import rpm_pkg::*; #(
  parameter int NUM_CH     = 4,
  parameter int WIN_W      = 32,
  parameter int RES_W      = 32,
  parameter int ADDR_W     = 8,
  parameter int WIDE_CH    = 1,
  parameter int SINGLE_CH  = 3,
  parameter int WIDE_RINGS = 6,
  parameter int STD_RINGS  = 4,
  parameter int BASE_DIV   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data
);

  localparam int EXT_OFS  = 4 * (NUM_CH + 1);
  localparam int STAT_OFS = EXT_OFS + 12;
  localparam int RES_OFS  = STAT_OFS + 4;

  logic [CTRL_BITS-1:0]         ctrl_q;
  logic                         ext_q;
  logic [NUM_CH-1:0][WIN_W-1:0] win_q;
  logic [NUM_CH-1:0][RES_W-1:0] res_vec;

  // Named per-channel events, observed by the bound checker.
  logic [NUM_CH-1:0] en_vec, start_vec, go_vec, run_vec, done_vec;

  rpm_regs #(
    .NUM_CH   (NUM_CH),
    .WIN_W    (WIN_W),
    .ADDR_W   (ADDR_W),
    .SINGLE_CH(SINGLE_CH)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .ctrl_q (ctrl_q),
    .ext_q  (ext_q),
    .win_q  (win_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int NR = ring_count(c, WIDE_CH, SINGLE_CH, WIDE_RINGS, STD_RINGS);

    logic [RIDX_W-1:0] ridx;
    logic              ring_w;

    assign en_vec[c]    = ctrl_q[enable_bit(c)];
    assign start_vec[c] = ctrl_q[start_bit(c)];

    if (c == SINGLE_CH) begin : g_sel_none
      assign ridx = '0;
    end else if (c == WIDE_CH) begin : g_sel_wide
      assign ridx = {ext_q, ctrl_q[sel_bit(c) +: 2]};
    end else begin : g_sel_std
      assign ridx = {1'b0, ctrl_q[sel_bit(c) +: 2]};
    end

    rpm_ring_bank #(
      .NUM_RINGS(NR),
      .BASE_DIV (BASE_DIV)
    ) u_bank (
      .osc_clk (osc_clk),
      .rst_n   (rst_n),
      .ring_sel(ridx),
      .ring_o  (ring_w)
    );

    rpm_chan #(
      .RES_W(RES_W),
      .WIN_W(WIN_W)
    ) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .ring_i   (ring_w),
      .enable_i (en_vec[c]),
      .start_i  (start_vec[c]),
      .win_len_i(win_q[c]),
      .go_o     (go_vec[c]),
      .run_o    (run_vec[c]),
      .done_o   (done_vec[c]),
      .result_o (res_vec[c])
    );
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(0))        rd_data = {16'h0, ctrl_q};
    if (rd_addr == ADDR_W'(EXT_OFS))  rd_data = {31'h0, ext_q};
    if (rd_addr == ADDR_W'(STAT_OFS)) rd_data = 32'(done_vec);
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_addr == ADDR_W'(4 * (c + 1)))   rd_data = 32'(win_q[c]);
      if (rd_addr == ADDR_W'(RES_OFS + 4 * c)) rd_data = 32'(res_vec[c]);
    end
  end

endmodule

// File: rtl/ring_perf_mon_chk.sv
module ring_perf_mon_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] en_vec,
  input logic [NUM_CH-1:0] start_vec,
  input logic [NUM_CH-1:0] go_vec,
  input logic [NUM_CH-1:0] run_vec,
  input logic [NUM_CH-1:0] done_vec
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R7: a cleared enable leaves the channel idle on the next edge
    a_r7_idle_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
      !en_vec[c] |=> (!run_vec[c] && !done_vec[c]));

    // R6: a cleared start drops done on the next edge
    a_r6_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
      !start_vec[c] |=> !done_vec[c]);

    // R3: done only ever follows a running window
    a_r3_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_vec[c]) |-> $past(run_vec[c]));

    // R3: running and done are exclusive
    a_r3_state_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(run_vec[c] && done_vec[c]));

    // R6: an accepted start always begins a fresh running phase
    a_r6_go_starts_run: assert property (@(posedge clk) disable iff (!rst_n)
      go_vec[c] |=> run_vec[c]);
  end

endmodule

bind ring_perf_mon ring_perf_mon_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en_vec   (en_vec),
  .start_vec(start_vec),
  .go_vec   (go_vec),
  .run_vec  (run_vec),
  .done_vec (done_vec)
);

// File: tb/ring_perf_mon_bench.sv
`timescale 1ns/1ps
module ring_perf_mon_bench;

  logic        clk = 1'b0;
  logic        osc_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  localparam logic [7:0] EXT_A  = 8'h14;
  localparam logic [7:0] STAT_A = 8'h20;
  localparam logic [7:0] RES_A  = 8'h24;
  localparam int         SAT    = 63;

  always #5 clk = ~clk;
  initial begin
    #1;
    forever #2 osc_clk = ~osc_clk;
  end

  ring_perf_mon #(.RES_W(6)) u_ring_perf_mon (
    .clk    (clk),
    .rst_n  (rst_n),
    .osc_clk(osc_clk),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic near(string tag, logic [31:0] act, int exp);
    int d;
    d = int'(act) - exp;
    checks++;
    if (d > 1 || d < -1) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d(+-1)", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic ctl(int mask, int val);
    wr(8'h00, {mask[15:0], val[15:0]});
  endtask

  function automatic int expected_count(int w, int idx);
    return (w * 10) / (8 * (3 + idx));
  endfunction

  // Full software sequence: enable, ring, window, start, poll, read, clear.
  task automatic measure(int ch, int idx, int w, output logic [31:0] res, output int lat);
    logic [31:0] st;
    ctl(1 << (4*ch+1), 1 << (4*ch+1));
    if (ch == 1) wr(EXT_A, {16'h0001, 15'h0, idx[2]});
    ctl(3 << (4*ch+2), (idx & 3) << (4*ch+2));
    wr(8'(4*(ch+1)), w);
    ctl(1 << (4*ch), 1 << (4*ch));
    lat = 0;
    forever begin
      @(posedge clk); lat++;
      @(negedge clk);
      rd(STAT_A, st);
      if (st[ch] || lat > w + 100) break;
    end
    rd(8'(RES_A + 4*ch), res);
    ctl(1 << (4*ch), 0);
    ctl(1 << (4*ch+1), 0);
  endtask

  initial begin
    #3_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, r1;
    int lat;

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R11: reset state
    rd(8'h00, v); check("R11 ctrl", v, 0);
    rd(EXT_A, v); check("R11 ext", v, 0);
    rd(STAT_A, v); check("R11 status", v, 0);
    rd(8'h04, v); check("R11 window0", v, 0);
    rd(RES_A, v); check("R11 result0", v, 0);

    // R1: masked control writes
    wr(8'h00, 32'h000C_FFFF); rd(8'h00, v); check("R1 masked set", v, 32'h000C);
    wr(8'h00, 32'h0004_0000); rd(8'h00, v); check("R1 masked clear", v, 32'h0008);
    wr(8'h00, 32'h0000_FFFF); rd(8'h00, v); check("R1 no mask no change", v, 32'h0008);
    wr(8'h00, 32'h0008_0000);

    // R9: single-ring channel has no selector
    wr(8'h00, 32'hC000_C000); rd(8'h00, v); check("R9 selector bits absent", v, 0);

    // R2: masked extension bit
    wr(EXT_A, 32'h0001_0001); rd(EXT_A, v); check("R2 ext set", v, 1);
    wr(EXT_A, 32'h0000_0000); rd(EXT_A, v); check("R2 ext held", v, 1);
    wr(EXT_A, 32'h0001_0000); rd(EXT_A, v); check("R2 ext clear", v, 0);

    // R4 R10 R3: sweep every selector value of every channel
    for (int ch = 0; ch < 4; ch++) begin
      int n;
      n = (ch == 1) ? 8 : ((ch == 3) ? 1 : 4);
      for (int idx = 0; idx < n; idx++) begin
        measure(ch, idx, 120, v, lat);
        check($sformatf("R3 latency ch%0d ring%0d", ch, idx), lat, 122);
        if (idx >= 6) check($sformatf("R10 silent ch%0d sel%0d", ch, idx), v, 0);
        else near($sformatf("R4 count ch%0d ring%0d", ch, idx), v, expected_count(120, idx));
      end
    end

    // R3: zero-length window
    measure(2, 0, 0, v, lat);
    check("R3 zero window latency", lat, 2);
    check("R3 zero window count", v, 0);

    // R8: saturation (100 edges into a 6-bit result)
    measure(0, 0, 240, v, lat);
    check("R8 saturated", v, SAT);

    // R6: clearing start drops done; restart counts from zero
    ctl(32'h2, 32'h2); ctl(32'hC, 0); wr(8'h04, 120);
    ctl(32'h1, 32'h1);
    repeat (130) @(posedge clk);
    @(negedge clk); rd(STAT_A, v); check("R6 done before clear", v[0], 1);
    ctl(32'h1, 0);
    @(posedge clk); @(negedge clk);
    rd(STAT_A, v); check("R6 done cleared", v[0], 0);
    ctl(32'h1, 32'h1);
    repeat (130) @(posedge clk);
    @(negedge clk); rd(RES_A, r1); near("R6 fresh count", r1, expected_count(120, 0));
    ctl(32'h1, 0); ctl(32'h2, 0);

    // R5: start without enable is ignored
    ctl(32'h1, 32'h1);
    repeat (200) @(posedge clk);
    @(negedge clk);
    rd(STAT_A, v); check("R5 no done", v[0], 0);
    rd(RES_A, v); check("R5 result kept", v, r1);
    ctl(32'h1, 0);

    // R7: abort by clearing enable
    ctl(32'h200, 32'h200); wr(8'h0C, 400);
    ctl(32'h100, 32'h100);
    repeat (50) @(posedge clk);
    ctl(32'h200, 0);
    repeat (450) @(posedge clk);
    @(negedge clk); rd(STAT_A, v); check("R7 aborted no done", v[2], 0);
    ctl(32'h100, 0);

    // R12: two channels at once
    ctl(32'h20E, 32'h202); wr(8'h04, 20); wr(8'h0C, 300);
    ctl(32'h101, 32'h101);
    repeat (40) @(posedge clk);
    @(negedge clk); rd(STAT_A, v); check("R12 status short", v, 32'h1);
    repeat (300) @(posedge clk);
    @(negedge clk); rd(STAT_A, v); check("R12 status both", v, 32'h5);
    rd(RES_A + 8, v); near("R12 result ch2", v, expected_count(300, 0) > SAT ? SAT : expected_count(300, 0));
    ctl(32'h101, 0); ctl(32'h202, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule